// File: doc/BRIEF.md
# Flash Data-Polling Completion Checker

This block sits on the host side of a parallel NOR flash. After software or a sequencer has written the command words that start a program or erase, it hands this block a target address and an expected data byte and pulses a start input. The block then runs status reads on a simple asynchronous read bus and decides, from the status bits the flash returns, whether the operation finished correctly, failed, or is still running.

Each status word is judged by two bits of its low byte. Bit 7 is the polling bit, and it equals bit 7 of the written data once the operation is complete. Bit 5 is the time-limit flag. If bit 7 does not match and bit 5 is clear, the block polls again. If bit 5 is set, the two bits can change at the same time, so the block takes exactly one more read and decides on its bit 7 alone. For an erase, the expected polling bit is 1, because erased cells read as ones. An optional poll cap stops a device that never answers. The block ends every operation with a single-clock done pulse that carries one pass or fail flag.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `fl_ce_n_o` and `fl_oe_n_o` are 1 and `busy_o`, `done_o`, `pass_o` and `fail_o` are 0.
- R2: A `start_i` pulse in an idle cycle latches `addr_i`, `expect_i`, `erase_i`, `access_i` and `cap_i`, and `busy_o` is 1 from the next cycle. A `start_i` pulse while `busy_o` is 1 has no effect on the address, the reads or the verdict.
- R3: Each status read drives `fl_ce_n_o` and `fl_oe_n_o` low together for `access_i`+1 clocks, with the latched address on `fl_addr_o`. `fl_data_i` is sampled at the clock edge that ends the read. Between two reads the strobes are high for exactly one clock.
- R4: When bit 7 of the sampled word equals the expected polling bit, the block reports pass on the first such read.
- R5: When bit 7 does not match and bit 5 of the same word is 0, the block issues another status read at the same address.
- R6: When bit 7 does not match and bit 5 is 1, the block issues exactly one recheck read. A bit-7 match on the recheck reports pass.
- R7: A bit-7 mismatch on the recheck read reports fail, whatever bit 5 holds.
- R8: With `erase_i`=1 at start, the expected polling bit is 1 and `expect_i` is ignored. With `erase_i`=0, it is `expect_i[7]`.
- R9: With `cap_i`=N>0, the N-th read that ends with a bit-7 mismatch and bit 5 at 0 reports fail. With `cap_i`=0 the number of polls is unlimited.
- R10: Every operation ends with `done_o` high for exactly one clock, with exactly one of `pass_o` or `fail_o` high. `busy_o` falls in that same cycle. `pass_o` and `fail_o` are 0 whenever `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| addr_i | input | ADDR_W (23) | Polling address |
| expect_i | input | 8 | Expected data byte; bit 7 is used |
| erase_i | input | 1 | 1 selects erase polling (expected bit 7 = 1) |
| access_i | input | ACC_W (4) | Extra strobe clocks per read (strobe width = value+1) |
| cap_i | input | CAP_W (16) | Poll cap, 0 = unlimited |
| fl_addr_o | output | ADDR_W (23) | Flash address |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_data_i | input | 16 | Flash read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| pass_o | output | 1 | Verdict pass, valid with done_o |
| fail_o | output | 1 | Verdict fail, valid with done_o |

## Verification
The bound checker watches the output rules on every cycle. These are the done pulse with its single verdict flag, the verdict flags staying quiet outside it, the strobes staying high while idle, the address holding steady during a read, and busy falling together with done. The order of decisions can only be shown by the bench scenarios, each driven by a scripted sequence of status words from a flash model. These scenarios cover the recheck after bit 5, the fail on a mismatched recheck, the erase polarity, the poll cap and a start pulse while busy. The per-clock reference model also pins down the strobe width and the one-clock gap between reads.

// File: rtl/poll_pkg.sv
package poll_pkg;
    localparam int DATA_W   = 16;
    localparam int POLL_BIT = 7;
    localparam int TOUT_BIT = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_POLL = 1'b1
    } poll_state_e;
endpackage

// File: rtl/poll_rd_seq.sv
module poll_rd_seq #(
    parameter int ACC_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go_i,
    input  logic [ACC_W-1:0]           wait_i,
    input  logic [poll_pkg::DATA_W-1:0] fl_data_i,
    output logic                       ce_n_o,
    output logic                       oe_n_o,
    output logic                       rdy_o,
    output logic [7:0]                 word_o
);
    typedef struct packed {
        logic             active;
        logic             oe_on;
        logic [ACC_W-1:0] cnt;
        logic             rdy;
        logic [7:0]       word;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b0;
        if (s_q.active) begin
            if (s_q.cnt == '0) begin
                s_d.active = 1'b0;
                s_d.oe_on  = 1'b0;
                s_d.rdy    = 1'b1;
                s_d.word   = fl_data_i[7:0];
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (go_i) begin
            s_d.active = 1'b1;
            s_d.oe_on  = 1'b1;
            s_d.cnt    = wait_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ce_n_o = ~s_q.active;
    assign oe_n_o = ~s_q.oe_on;
    assign rdy_o  = s_q.rdy;
    assign word_o = s_q.word;
endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
    parameter int CAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CAP_W-1:0] limit_i,
    output logic             last_o
);
    logic [CAP_W-1:0] cnt_d, cnt_q;
    logic [CAP_W:0]   next_cnt;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign next_cnt = {1'b0, cnt_q} + 1'b1;
    assign last_o   = (limit_i != '0) && (next_cnt >= {1'b0, limit_i});
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
    parameter int ADDR_W = 23,
    parameter int ACC_W  = 4,
    parameter int CAP_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [7:0]                  expect_i,
    input  logic                        erase_i,
    input  logic [ACC_W-1:0]            access_i,
    input  logic [CAP_W-1:0]            cap_i,
    output logic [ADDR_W-1:0]           fl_addr_o,
    output logic                        fl_ce_n_o,
    output logic                        fl_oe_n_o,
    input  logic [poll_pkg::DATA_W-1:0] fl_data_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        pass_o,
    output logic                        fail_o
);
    import poll_pkg::*;

    typedef struct packed {
        poll_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic              exp7;
        logic [ACC_W-1:0]  acc;
        logic [CAP_W-1:0]  cap;
        logic              recheck;
        logic              done;
        logic              pass;
        logic              fail;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             go;
    logic             lim_clr;
    logic             lim_inc;
    logic             lim_last;
    logic             rd_rdy;
    logic [7:0]       rd_word;
    logic [ACC_W-1:0] rd_wait;
    logic             bit_match;

    assign bit_match = (rd_word[POLL_BIT] == c_q.exp7);
    assign rd_wait   = (c_q.state == ST_IDLE) ? access_i : c_q.acc;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.pass = 1'b0;
        c_d.fail = 1'b0;
        go       = 1'b0;
        lim_clr  = 1'b0;
        lim_inc  = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.state   = ST_POLL;
                    c_d.addr    = addr_i;
                    c_d.exp7    = erase_i ? 1'b1 : expect_i[POLL_BIT];
                    c_d.acc     = access_i;
                    c_d.cap     = cap_i;
                    c_d.recheck = 1'b0;
                    go          = 1'b1;
                    lim_clr     = 1'b1;
                end
            end
            ST_POLL: begin
                if (rd_rdy) begin
                    if (bit_match) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                        c_d.pass  = 1'b1;
                    end else if (c_q.recheck) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                        c_d.fail  = 1'b1;
                    end else if (rd_word[TOUT_BIT]) begin
                        c_d.recheck = 1'b1;
                        go          = 1'b1;
                    end else if (lim_last) begin
                        c_d.state = ST_IDLE;
                        c_d.done  = 1'b1;
                        c_d.fail  = 1'b1;
                    end else begin
                        lim_inc = 1'b1;
                        go      = 1'b1;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    poll_rd_seq #(.ACC_W(ACC_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .wait_i    (rd_wait),
        .fl_data_i (fl_data_i),
        .ce_n_o    (fl_ce_n_o),
        .oe_n_o    (fl_oe_n_o),
        .rdy_o     (rd_rdy),
        .word_o    (rd_word)
    );

    poll_limit #(.CAP_W(CAP_W)) u_lim (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (lim_clr),
        .inc_i   (lim_inc),
        .limit_i (c_q.cap),
        .last_o  (lim_last)
    );

    assign fl_addr_o = c_q.addr;
    assign busy_o    = (c_q.state != ST_IDLE);
    assign done_o    = c_q.done;
    assign pass_o    = c_q.pass;
    assign fail_o    = c_q.fail;
endmodule

// File: rtl/poll_chk.sv
module poll_chk #(
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fl_addr_o,
    input logic              fl_ce_n_o,
    input logic              fl_oe_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              fail_o
);
    a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({pass_o, fail_o}));

    a_r10_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!pass_o && !fail_o));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!busy_o && $past(busy_o)));

    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (fl_ce_n_o && fl_oe_n_o));

    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n_o && $past(!fl_ce_n_o)) |-> $stable(fl_addr_o));

    a_r3_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_ce_n_o) |-> $fell(fl_oe_n_o));
endmodule

bind flash_poll_ctrl poll_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_addr_o (fl_addr_o),
    .fl_ce_n_o (fl_ce_n_o),
    .fl_oe_n_o (fl_oe_n_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
);

// File: tb/sim_flash_poll_ctrl.sv
`timescale 1ns/1ps
module sim_flash_poll_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [22:0] addr_i = '0;
    logic [7:0]  expect_i = '0;
    logic        erase_i = 1'b0;
    logic [3:0]  access_i = '0;
    logic [15:0] cap_i = '0;
    logic [22:0] fl_addr_o;
    logic        fl_ce_n_o, fl_oe_n_o;
    logic [15:0] fl_data_i = 16'hFFFF;
    logic        busy_o, done_o, pass_o, fail_o;

    always #2 clk = ~clk;

    flash_poll_ctrl u0 (.*);

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int rd_cnt = 0;
    logic got_done = 1'b0;
    logic got_pass = 1'b0;
    logic prev_ce = 1'b1;
    logic [15:0] dev_q[$];

    // behavioural reference state
    logic        m_busy = 0, m_done = 0, m_pass = 0, m_fail = 0;
    logic        m_eval = 0, m_recheck = 0, m_exp7 = 0;
    int          m_left = 0, m_polls = 0, m_acc = 0, m_cap = 0;
    logic [22:0] m_addr = '0;
    logic [7:0]  m_word = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit prev_eval;
        bit fin;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0;
            m_eval = 0; m_left = 0;
        end else begin
            prev_eval = m_eval;
            m_eval = 0;
            m_done = 0; m_pass = 0; m_fail = 0;
            if (m_left > 0) begin
                if (m_left == 1) begin
                    m_word = fl_data_i[7:0];
                    m_eval = 1;
                end
                m_left--;
            end
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_addr = addr_i;
                    m_exp7 = erase_i ? 1'b1 : expect_i[7];
                    m_acc = access_i; m_cap = cap_i;
                    m_polls = 0; m_recheck = 0;
                    m_left = m_acc + 1;
                end
            end else if (prev_eval) begin
                fin = 0;
                if (m_word[7] == m_exp7) begin
                    fin = 1; m_pass = 1;
                end else if (m_recheck) begin
                    fin = 1; m_fail = 1;
                end else if (m_word[5]) begin
                    m_recheck = 1; m_left = m_acc + 1;
                end else begin
                    m_polls++;
                    if (m_cap != 0 && m_polls >= m_cap) begin
                        fin = 1; m_fail = 1;
                    end else begin
                        m_left = m_acc + 1;
                    end
                end
                if (fin) begin
                    m_done = 1; m_busy = 0;
                end
            end
        end
    end

    // compare and flash device model, away from the edge
    always @(posedge clk) begin
        #1;
        cycles++;
        if (rst_n) begin
            check(fl_ce_n_o == !(m_left > 0), "R3", "ce_n", fl_ce_n_o, !(m_left > 0));
            check(fl_oe_n_o == !(m_left > 0), "R3", "oe_n", fl_oe_n_o, !(m_left > 0));
            if (m_left > 0)
                check(fl_addr_o == m_addr, "R3", "addr", fl_addr_o, m_addr);
            check(busy_o == m_busy, "R2", "busy", busy_o, m_busy);
            check({done_o, pass_o, fail_o} == {m_done, m_pass, m_fail}, "R10",
                  "done/pass/fail", {done_o, pass_o, fail_o}, {m_done, m_pass, m_fail});
            if (done_o) begin
                got_done = 1'b1;
                got_pass = pass_o;
            end
            if (prev_ce && !fl_ce_n_o) rd_cnt++;
            if (!prev_ce && fl_ce_n_o && dev_q.size() > 0) void'(dev_q.pop_front());
        end
        prev_ce = fl_ce_n_o;
        fl_data_i = (dev_q.size() > 0) ? dev_q[0] : 16'hFFFF;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic run_op(input logic [22:0] a, input logic [7:0] e, input logic er,
                          input logic [3:0] acc, input logic [15:0] cap,
                          input logic poke, input logic exp_pass,
                          input int exp_reads, input string req);
        int n;
        @(negedge clk);
        addr_i = a; expect_i = e; erase_i = er; access_i = acc; cap_i = cap;
        fl_data_i = (dev_q.size() > 0) ? dev_q[0] : 16'hFFFF;
        got_done = 0; rd_cnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            addr_i = a ^ 23'h155; expect_i = ~e; access_i = 4'd0;
            start_i = 1'b1;
            repeat (2) @(negedge clk);
            start_i = 1'b0;
        end
        n = 0;
        while (!got_done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(got_done, req, "done seen", got_done, 1);
        check(got_pass == exp_pass, req, "verdict pass", got_pass, exp_pass);
        check(rd_cnt == exp_reads, req, "read count", rd_cnt, exp_reads);
        dev_q.delete();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(fl_ce_n_o && fl_oe_n_o, "R1", "strobes in reset", {fl_ce_n_o, fl_oe_n_o}, 2'b11);
        check(!busy_o && !done_o && !pass_o && !fail_o, "R1", "flags in reset",
              {busy_o, done_o, pass_o, fail_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && fl_ce_n_o, "R1", "idle after reset", {busy_o, fl_ce_n_o}, 2'b01);

        // R4: immediate bit-7 match
        dev_q = '{16'h00A5};
        run_op(23'h12345, 8'hA5, 0, 4'd3, 16'd0, 0, 1, 1, "R4");
        // R5: bit5 clear mismatches then match
        dev_q = '{16'h0080, 16'h0080, 16'h003C};
        run_op(23'h00040, 8'h3C, 0, 4'd2, 16'd0, 0, 1, 3, "R5");
        // R6: bit5 set, recheck matches
        dev_q = '{16'h00A0, 16'h0000};
        run_op(23'h7FFFF, 8'h11, 0, 4'd1, 16'd0, 0, 1, 2, "R6");
        dev_q = '{16'h0080, 16'h00A0, 16'h0010};
        run_op(23'h00002, 8'h11, 0, 4'd0, 16'd0, 0, 1, 3, "R6");
        // R7: recheck mismatch, bit5 irrelevant
        dev_q = '{16'h00A0, 16'h0080};
        run_op(23'h00100, 8'h00, 0, 4'd4, 16'd0, 0, 0, 2, "R7");
        // R8: erase expects bit7=1 regardless of expect_i
        dev_q = '{16'h0000, 16'h00FF};
        run_op(23'h40000, 8'h00, 1, 4'd2, 16'd0, 0, 1, 2, "R8");
        dev_q = '{16'h0000};
        run_op(23'h40000, 8'h00, 0, 4'd2, 16'd0, 0, 1, 1, "R8");
        // R9: cap of 3 ends a silent device
        dev_q = '{16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080};
        run_op(23'h00777, 8'h00, 0, 4'd1, 16'd3, 0, 0, 3, "R9");
        // R9: cap 0 unlimited
        dev_q = '{16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0080, 16'h0000};
        run_op(23'h00777, 8'h00, 0, 4'd0, 16'd0, 0, 1, 6, "R9");
        // R2: start while busy is ignored
        dev_q = '{16'h0080, 16'h0080, 16'h0000};
        run_op(23'h0ABCD, 8'h00, 0, 4'd6, 16'd0, 1, 1, 3, "R2");
        // R3: long strobe, R10 verdict pulse covered by per-cycle compare
        dev_q = '{16'h00FF};
        run_op(23'h00001, 8'hFF, 0, 4'd15, 16'd0, 0, 1, 1, "R3");
        dev_q = '{16'h0020, 16'h0020};
        run_op(23'h00003, 8'h80, 0, 4'd0, 16'd1, 0, 0, 2, "R10");

        finish_run();
    end
endmodule